// File: doc/BRIEF.md
# Scheduler-Gated Packet Copy Engine

This block lives inside a bridge that sits between a controlled peripheral and host memory. The peripheral writes packets into buffers in local RAM. Driver software then posts two kinds of descriptors. A source descriptor carries the local word address and the length in words of a filled buffer. A destination descriptor carries the host word address of an empty buffer. The engine pairs the descriptors in the order they were posted. It copies each packet one word at a time: it reads a word through a request/acknowledge port on local RAM, then writes that word through a second request/acknowledge port toward the host.

A global bus scheduler decides when each bridge may use the shared memory path. The engine tells the scheduler it has work by holding `dataRdy` high. The scheduler lets it move data by holding `block` low. When `block` goes high, the engine finishes the word it has in flight, then parks with its addresses and remaining count intact. When `block` falls again, it carries on from the next word. Descriptors leave their queues when a packet starts. Each finished packet counts as one completion. A coalescing stage turns those completions into a single interrupt pulse, raised either after a programmable number of packets or after a programmable quiet period.

Top module: `gatedDescDma`

## Requirements
- R1: After reset both queues report empty and not full, and `dataRdy`, `dstStarved`, `rdReq`, `wrReq`, `irq` and both overflow flags are low.
- R2: Packets are served in posting order. Word i of a packet is read from source address + i, and that same data is written to destination address + i, for i from 0 to length−1 in ascending order.
- R3: `dataRdy` is high exactly when the source queue holds an entry or a packet is being copied, and low otherwise.
- R4: While `block` is high, no new word read starts, including the first word of a packet. A word whose read has already begun is still written. After `block` falls, copying resumes at the following word.
- R5: A packet starts only when both queues are non-empty. `dstStarved` is high whenever the source queue is non-empty and the destination queue is empty.
- R6: `irq` is a one-cycle pulse, raised once the number of completions since the last pulse reaches `coalThresh`. The pulse clears that count.
- R7: If at least one completion is pending and no further packet completes for `coalTimeout` cycles, `irq` pulses once and the count clears.
- R8: Each queue holds `DEPTH` entries and reports full and empty. A push into a full queue is dropped, and the overflow flag of that queue is set and stays set until reset.
- R9: A source descriptor with length 0 is retired without any memory access, and it counts as one completion.
- R10: Once `rdReq` or `wrReq` is raised, it stays high with a stable address (and stable write data) until the matching acknowledge is seen at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| block | input | 1 | Scheduler hold; high pauses copying at a word boundary |
| srcPush | input | 1 | Post a source descriptor |
| srcPushAddr | input | ADDR_W | Local word address of the filled buffer |
| srcPushLen | input | LEN_W | Packet length in words |
| dstPush | input | 1 | Post a destination descriptor |
| dstPushAddr | input | ADDR_W | Host word address of the empty buffer |
| coalThresh | input | CNT_W | Completions per interrupt |
| coalTimeout | input | TMO_W | Quiet cycles before a pending interrupt is forced |
| srcFull | output | 1 | Source queue full |
| srcEmpty | output | 1 | Source queue empty |
| dstFull | output | 1 | Destination queue full |
| dstEmpty | output | 1 | Destination queue empty |
| srcOverflow | output | 1 | Sticky: a source push was dropped |
| dstOverflow | output | 1 | Sticky: a destination push was dropped |
| dstStarved | output | 1 | Source work waiting but no destination buffer |
| dataRdy | output | 1 | Backlog indication to the scheduler |
| rdReq | output | 1 | Local RAM read request |
| rdAddr | output | ADDR_W | Local RAM read word address |
| rdAck | input | 1 | Local RAM read acknowledge |
| rdData | input | DATA_W | Local RAM read data, valid with rdAck |
| wrReq | output | 1 | Host write request |
| wrAddr | output | ADDR_W | Host write word address |
| wrData | output | DATA_W | Host write data |
| wrAck | input | 1 | Host write acknowledge |
| irq | output | 1 | Coalesced completion pulse |

## Verification
A wrong pointer or length register inside the engine shows up on the next handshake of the write port. The write carries either the wrong host address or data belonging to the wrong local word, and the scoreboard catches this on that very transaction. If the control state misreads `block`, a read request appears during a scheduler hold; the assertions flag it at once, and the bench sees a write count that keeps rising during a hold window of several tens of cycles. If a queue or the coalescing counter holds a bad state, the effect comes later: a pairing goes missing or extra, so the scoreboard finishes non-empty or meets an unexpected write, or an interrupt is missing or extra, which is counted at the end of each threshold or timeout window.

// File: rtl/dmaPkg.sv
package dmaPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RDREQ,
    ST_WRREQ,
    ST_DONE
  } dmaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // pop both queue heads into the working registers
    logic capture;  // latch read data
    logic advance;  // step addresses, decrement remaining count
    logic done;     // packet retired
  } dmaStrobe_t;

endpackage

// File: rtl/descFifo.sv
module descFifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        st,
  input  logic              srcPush,
  input  logic [ADDR_W-1:0] srcPushAddr,
  input  logic [LEN_W-1:0]  srcPushLen,
  input  logic              dstPush,
  input  logic [ADDR_W-1:0] dstPushAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              srcFull,
  output logic              srcEmpty,
  output logic              dstFull,
  output logic              dstEmpty,
  output logic              srcOverflow,
  output logic              dstOverflow,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              remZero
);
  localparam int SRC_W = ADDR_W + LEN_W;

  logic [SRC_W-1:0]  srcHead;
  logic [ADDR_W-1:0] dstHead;
  logic [ADDR_W-1:0] srcPtr, dstPtr;
  logic [LEN_W-1:0]  remaining;
  logic [DATA_W-1:0] dataReg;

  descFifo #(.W(SRC_W), .DEPTH(DEPTH)) uSrcQ (
    .clk(clk), .rstN(rstN), .push(srcPush),
    .pushData({srcPushAddr, srcPushLen}), .pop(st.load),
    .head(srcHead), .full(srcFull), .empty(srcEmpty), .overflow(srcOverflow)
  );

  descFifo #(.W(ADDR_W), .DEPTH(DEPTH)) uDstQ (
    .clk(clk), .rstN(rstN), .push(dstPush),
    .pushData(dstPushAddr), .pop(st.load),
    .head(dstHead), .full(dstFull), .empty(dstEmpty), .overflow(dstOverflow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr    <= '0;
      dstPtr    <= '0;
      remaining <= '0;
      dataReg   <= '0;
    end else begin
      if (st.load) begin
        srcPtr    <= srcHead[SRC_W-1:LEN_W];
        remaining <= srcHead[LEN_W-1:0];
        dstPtr    <= dstHead;
      end
      if (st.capture) dataReg <= rdData;
      if (st.advance) begin
        srcPtr    <= srcPtr + 1'b1;
        dstPtr    <= dstPtr + 1'b1;
        remaining <= remaining - 1'b1;
      end
    end
  end

  assign rdAddr  = srcPtr;
  assign wrAddr  = dstPtr;
  assign wrData  = dataReg;
  assign remZero = (remaining == '0);
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       block,
  input  logic       srcEmpty,
  input  logic       dstEmpty,
  input  logic       remZero,
  input  logic       rdAck,
  input  logic       wrAck,
  output dmaStrobe_t st,
  output logic       rdReq,
  output logic       wrReq,
  output logic       busy
);
  dmaState_t state, nextState;

  always_comb begin
    st        = '0;
    nextState = state;
    case (state)
      ST_IDLE:
        if (!srcEmpty && !dstEmpty && !block) begin
          st.load   = 1'b1;
          nextState = ST_ARB;
        end
      ST_ARB:
        if (remZero)     nextState = ST_DONE;
        else if (!block) nextState = ST_RDREQ;
      ST_RDREQ:
        if (rdAck) begin
          st.capture = 1'b1;
          nextState  = ST_WRREQ;
        end
      ST_WRREQ:
        if (wrAck) begin
          st.advance = 1'b1;
          nextState  = ST_ARB;
        end
      ST_DONE: begin
        st.done   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign rdReq = (state == ST_RDREQ);
  assign wrReq = (state == ST_WRREQ);
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/irqCoalesce.sv
module irqCoalesce #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             done,
  input  logic [CNT_W-1:0] coalThresh,
  input  logic [TMO_W-1:0] coalTimeout,
  output logic             irq
);
  logic [CNT_W-1:0] pending;
  logic [TMO_W-1:0] quiet;
  logic [CNT_W:0]   pendNext;
  logic [TMO_W:0]   quietNext;
  logic             hitCount, hitTime;

  assign pendNext  = {1'b0, pending} + 1'b1;
  assign quietNext = {1'b0, quiet} + 1'b1;
  assign hitCount  = done && (pendNext >= {1'b0, coalThresh});
  assign hitTime   = !done && (pending != '0) && (quietNext >= {1'b0, coalTimeout});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      quiet   <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= hitCount || hitTime;
      if (hitCount || hitTime) begin
        pending <= '0;
        quiet   <= '0;
      end else if (done) begin
        pending <= pendNext[CNT_W-1:0];
        quiet   <= '0;
      end else if (pending != '0) begin
        quiet <= quietNext[TMO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gatedDescDma.sv
module gatedDescDma
  import dmaPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8,
  parameter int TMO_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              block,
  input  logic              srcPush,
  input  logic [ADDR_W-1:0] srcPushAddr,
  input  logic [LEN_W-1:0]  srcPushLen,
  input  logic              dstPush,
  input  logic [ADDR_W-1:0] dstPushAddr,
  input  logic [CNT_W-1:0]  coalThresh,
  input  logic [TMO_W-1:0]  coalTimeout,
  output logic              srcFull,
  output logic              srcEmpty,
  output logic              dstFull,
  output logic              dstEmpty,
  output logic              srcOverflow,
  output logic              dstOverflow,
  output logic              dstStarved,
  output logic              dataRdy,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrAck,
  output logic              irq
);
  dmaStrobe_t strobe;
  logic       remZero;
  logic       busy;

  dmaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .block(block),
    .srcEmpty(srcEmpty), .dstEmpty(dstEmpty), .remZero(remZero),
    .rdAck(rdAck), .wrAck(wrAck),
    .st(strobe), .rdReq(rdReq), .wrReq(wrReq), .busy(busy)
  );

  dmaDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .st(strobe),
    .srcPush(srcPush), .srcPushAddr(srcPushAddr), .srcPushLen(srcPushLen),
    .dstPush(dstPush), .dstPushAddr(dstPushAddr), .rdData(rdData),
    .srcFull(srcFull), .srcEmpty(srcEmpty), .dstFull(dstFull), .dstEmpty(dstEmpty),
    .srcOverflow(srcOverflow), .dstOverflow(dstOverflow),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData), .remZero(remZero)
  );

  irqCoalesce #(.CNT_W(CNT_W), .TMO_W(TMO_W)) uCoal (
    .clk(clk), .rstN(rstN), .done(strobe.done),
    .coalThresh(coalThresh), .coalTimeout(coalTimeout), .irq(irq)
  );

  assign dataRdy    = !srcEmpty || busy;
  assign dstStarved = !srcEmpty && dstEmpty;
endmodule

// File: rtl/gatedDescDmaChecker.sv
module gatedDescDmaChecker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              block,
  input logic              srcFull,
  input logic              srcEmpty,
  input logic              dstFull,
  input logic              dstEmpty,
  input logic              srcOverflow,
  input logic              dstOverflow,
  input logic              dataRdy,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrAck,
  input logic              irq
);
  // R10: requests held with stable address until acknowledged
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(rdAddr));
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq && $stable(wrAddr) && $stable(wrData));
  // R4: a read only starts after block was seen low
  p_block_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdReq) |-> $past(!block));
  // R3: queued source work always shows as backlog
  p_backlog_r3: assert property (@(posedge clk) disable iff (!rstN)
    !srcEmpty |-> dataRdy);
  // R6: interrupt is a single-cycle pulse
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R8: overflow flags are sticky, full and empty exclusive
  p_src_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    srcOverflow |=> srcOverflow);
  p_dst_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    dstOverflow |=> dstOverflow);
  p_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(srcFull && srcEmpty) && !(dstFull && dstEmpty));
  // R10: never both ports requesting at once
  p_one_port_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdReq, wrReq}) <= 1);
endmodule

bind gatedDescDma gatedDescDmaChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .block(block),
  .srcFull(srcFull), .srcEmpty(srcEmpty), .dstFull(dstFull), .dstEmpty(dstEmpty),
  .srcOverflow(srcOverflow), .dstOverflow(dstOverflow), .dataRdy(dataRdy),
  .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
  .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck), .irq(irq)
);

// File: tb/sim_gatedDescDma.sv
module sim_gatedDescDma;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 8;
  localparam int TMO_W  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic block = 1'b0;
  logic srcPush = 1'b0, dstPush = 1'b0;
  logic [ADDR_W-1:0] srcPushAddr = '0, dstPushAddr = '0;
  logic [LEN_W-1:0]  srcPushLen = '0;
  logic [CNT_W-1:0]  coalThresh = 8'd1;
  logic [TMO_W-1:0]  coalTimeout = 12'hFFF;
  logic srcFull, srcEmpty, dstFull, dstEmpty, srcOverflow, dstOverflow;
  logic dstStarved, dataRdy, rdReq, wrReq, irq;
  logic rdAck = 1'b0, wrAck = 1'b0;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [DATA_W-1:0] rdData = '0, wrData;

  always #10 clk = ~clk;  // 50 MHz

  gatedDescDma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH),
                 .CNT_W(CNT_W), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rstN(rstN), .block(block),
    .srcPush(srcPush), .srcPushAddr(srcPushAddr), .srcPushLen(srcPushLen),
    .dstPush(dstPush), .dstPushAddr(dstPushAddr),
    .coalThresh(coalThresh), .coalTimeout(coalTimeout),
    .srcFull(srcFull), .srcEmpty(srcEmpty), .dstFull(dstFull), .dstEmpty(dstEmpty),
    .srcOverflow(srcOverflow), .dstOverflow(dstOverflow), .dstStarved(dstStarved),
    .dataRdy(dataRdy), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int rdCount = 0, wrCount = 0, irqCount = 0;
  logic [ADDR_W+DATA_W-1:0] expQ[$];
  logic [7:0] lfsr = 8'h5B;
  logic prevWrWait = 1'b0;
  logic [ADDR_W+DATA_W-1:0] prevWr = '0;

  function automatic logic [DATA_W-1:0] localWord(input logic [ADDR_W-1:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Memory models and scoreboard monitor, all on the falling edge
  always @(negedge clk) begin
    logic newRd, newWr;
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    newRd = rdReq && lfsr[0];
    newWr = wrReq && lfsr[2];
    if (irq) irqCount++;
    // R10: write held stable while waiting
    if (prevWrWait && wrReq)
      check({wrAddr, wrData} == prevWr, "R10 write stable", {wrAddr, wrData}, prevWr);
    prevWrWait = wrReq && !newWr;
    prevWr     = {wrAddr, wrData};
    if (newRd) begin
      rdCount++;
      rdData <= localWord(rdAddr);
    end
    if (newWr) begin
      wrCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected write", {wrAddr, wrData}, 0);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = expQ.pop_front();
        check({wrAddr, wrData} == e, "R2 write addr/data", {wrAddr, wrData}, e);
      end
    end
    rdAck <= newRd;
    wrAck <= newWr;
  end

  task automatic pushSrc(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
    @(negedge clk); srcPush = 1'b1; srcPushAddr = a; srcPushLen = l;
    @(negedge clk); srcPush = 1'b0;
  endtask

  task automatic pushDst(input logic [ADDR_W-1:0] a);
    @(negedge clk); dstPush = 1'b1; dstPushAddr = a;
    @(negedge clk); dstPush = 1'b0;
  endtask

  task automatic expectPkt(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d, input int len);
    for (int i = 0; i < len; i++)
      expQ.push_back({d + ADDR_W'(i), localWord(s + ADDR_W'(i))});
  endtask

  task automatic sendPacket(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d, input int len);
    expectPkt(s, d, len);
    pushSrc(s, LEN_W'(len));
    pushDst(d);
  endtask

  task automatic drain();
    int n = 0;
    repeat (3) @(negedge clk);
    while ((dataRdy || expQ.size() != 0) && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, rbase, ibase;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(srcEmpty && dstEmpty && !srcFull && !dstFull, "R1 queue flags",
          {srcEmpty, dstEmpty, srcFull, dstFull}, 4'b1100);
    check(!dataRdy && !dstStarved && !rdReq && !wrReq && !irq && !srcOverflow && !dstOverflow,
          "R1 outputs idle", {dataRdy, dstStarved, rdReq, wrReq, irq, srcOverflow, dstOverflow}, 0);

    // R2 basic copies, two packets in order
    sendPacket(16'h0100, 16'h8000, 3);
    sendPacket(16'h0200, 16'h9000, 5);
    drain();
    check(expQ.size() == 0, "R2 all words written", expQ.size(), 0);
    check(!dataRdy, "R3 low after drain", dataRdy, 0);

    // R5 starved: source but no destination
    rbase = rdCount;
    pushSrc(16'h0300, 8'd2);
    repeat (20) @(negedge clk);
    check(dstStarved, "R5 starved flag", dstStarved, 1);
    check(dataRdy, "R3 high with queued source", dataRdy, 1);
    check(rdCount == rbase, "R5 no read without destination", rdCount - rbase, 0);
    expectPkt(16'h0300, 16'hA000, 2);
    pushDst(16'hA000);
    @(negedge clk);
    check(!dstStarved, "R5 starved clears", dstStarved, 0);
    drain();
    check(expQ.size() == 0, "R5 packet after destination", expQ.size(), 0);

    // R4 block before start
    block = 1'b1;
    rbase = rdCount;
    sendPacket(16'h0400, 16'hB000, 4);
    repeat (30) @(negedge clk);
    check(rdCount == rbase, "R4 no read while blocked", rdCount - rbase, 0);
    check(dataRdy, "R3 backlog while blocked", dataRdy, 1);
    block = 1'b0;
    drain();
    check(expQ.size() == 0, "R4 resumes after release", expQ.size(), 0);

    // R4 block mid-packet
    base = wrCount;
    sendPacket(16'h0500, 16'hC000, 6);
    wait (wrCount == base + 2);
    block = 1'b1;
    rbase = rdCount;
    repeat (40) @(negedge clk);
    check(wrCount == base + 2, "R4 halt at word boundary", wrCount - base, 2);
    check(rdCount == rbase, "R4 no read during hold", rdCount - rbase, 0);
    check(dataRdy, "R3 high mid-packet", dataRdy, 1);
    block = 1'b0;
    drain();
    check(expQ.size() == 0 && wrCount == base + 6, "R4 remaining words", wrCount - base, 6);

    // R9 zero-length packet
    ibase = irqCount; base = wrCount; rbase = rdCount;
    sendPacket(16'h0600, 16'hD000, 0);
    drain();
    check(irqCount == ibase + 1, "R9 counts as completion", irqCount - ibase, 1);
    check(wrCount == base && rdCount == rbase, "R9 no memory access",
          (wrCount - base) + (rdCount - rbase), 0);

    // R6 threshold coalescing
    coalThresh = 8'd3;
    ibase = irqCount;
    sendPacket(16'h0700, 16'hE000, 1);
    sendPacket(16'h0710, 16'hE100, 2);
    drain();
    check(irqCount == ibase, "R6 no irq below threshold", irqCount - ibase, 0);
    sendPacket(16'h0720, 16'hE200, 1);
    drain();
    check(irqCount == ibase + 1, "R6 one irq at threshold", irqCount - ibase, 1);

    // R7 timeout
    coalThresh = 8'd10;
    coalTimeout = 12'd60;
    ibase = irqCount;
    sendPacket(16'h0800, 16'hF000, 2);
    drain();
    repeat (20) @(negedge clk);
    check(irqCount == ibase, "R7 no irq before timeout", irqCount - ibase, 0);
    repeat (60) @(negedge clk);
    check(irqCount == ibase + 1, "R7 irq after timeout", irqCount - ibase, 1);
    repeat (100) @(negedge clk);
    check(irqCount == ibase + 1, "R7 single irq", irqCount - ibase, 1);

    // R8 full and overflow
    coalThresh = 8'd1;
    block = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      sendPacket(16'h1000 + ADDR_W'(i * 16), 16'h2000 + ADDR_W'(i * 16), 2);
    @(negedge clk);
    check(srcFull && dstFull, "R8 full flags", {srcFull, dstFull}, 2'b11);
    check(!srcOverflow && !dstOverflow, "R8 no overflow yet", {srcOverflow, dstOverflow}, 0);
    pushSrc(16'h1F00, 8'd3);
    pushDst(16'h2F00);
    @(negedge clk);
    check(srcOverflow && dstOverflow, "R8 overflow set", {srcOverflow, dstOverflow}, 2'b11);
    block = 1'b0;
    drain();
    check(expQ.size() == 0 && srcEmpty && dstEmpty, "R8 dropped entries absent",
          {srcEmpty, dstEmpty}, 2'b11);
    check(srcOverflow && dstOverflow, "R8 overflow sticky", {srcOverflow, dstOverflow}, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule